// File: doc/BRIEF.md
# Scaled SCL Phase Timer

This block sets the timing of the SCL clock for an I2C bus master. One timing word supplies three fields: a prescaler exponent, which makes one base tick last 2^exponent system clocks, and separate high and low phase lengths counted in base ticks. Each phase length is stored as its value minus one. The block drives SCL low during the low phase and releases it for the high phase. It also gives the byte engine three single-cycle strobes: one in the last cycle before SCL drops, one in the last cycle before SCL is released, and one at the middle of the high phase, where SDA is sampled.

The high phase counts only while the sensed SCL line is high. A slave that holds SCL low after release therefore stretches the high phase by exactly the time it holds the line. The three fields are captured at the start of every period, so software can rewrite the timing word while the clock runs. The other timing fields in the same word, in bits 31:20, are never used. When `enable` is low the block idles with SCL released. Each enable starts the prescaler from zero.

Top module: `scl_timebase`

## Requirements
- R1: While reset is asserted, and in every cycle after a clock edge that saw `enable` low, `scl_drive_low`, `rise_stb` and `sample_stb` are 0.
- R2: With exponent b and low field L, every low phase holds `scl_drive_low` at 1 for exactly (L+1)·2^b cycles.
- R3: With high field H and no stretching, every high phase holds `scl_drive_low` at 0 for exactly (H+1)·2^b cycles.
- R4: With no stretching, the SCL period is 2^b·((H+1)+(L+1)) system clocks.
- R5: The high field is in bits 19:16 of `timing_reg`, the low field in bits 15:12 and the exponent in bits 3:0. Bits 31:20 and 11:4 have no effect on timing.
- R6: A cycle of the high phase in which `scl_in` is 0 is not counted. A hold of n cycles lengthens that high phase by exactly n cycles.
- R7: `sample_stb` pulses exactly once in each high phase, while SCL is released and `scl_in` is 1. It pulses in the counted high cycle with zero-based index floor((H+1)·2^b / 2).
- R8: `rise_stb` is 1 only in the last cycle of a low phase. `fall_stb` is 1 only in the last counted cycle of a high phase, or in the idle cycle in which `enable` is seen high. The two never pulse together.
- R9: Dropping `enable` ends the current phase at the next clock edge. After `enable` returns, the first low phase has its full length.
- R10: The fields are captured in the cycle `fall_stb` is 1. A change to `timing_reg` in the middle of a period takes effect from the next low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run the generator; low forces idle with SCL released |
| timing_reg | input | 32 | Timing word (exponent 3:0, low 15:12, high 19:16) |
| scl_in | input | 1 | Sensed level of the SCL line |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| fall_stb | output | 1 | Last cycle before SCL is pulled low |
| rise_stb | output | 1 | Last cycle before SCL is released |
| sample_stb | output | 1 | Middle of the counted high phase |

## Verification
The assertions check the cycle-level rules on every cycle:
- Idle is quiet after `enable` is seen low.
- Each edge strobe is followed by the matching change of `scl_drive_low`.
- A low phase never ends without a rise strobe.
- The two edge strobes never coincide.
- No sample strobe occurs while SCL is held low, either by the block or by a stretching slave.

Only the bench scenarios can show the arithmetic of the block. These cover the exact phase lengths and their sum for many exponent and field mixes, the midpoint index including its rounding, and the extension caused by stretching. They also cover the deferred pickup of a rewritten timing word and the full-length first phase after re-enable.

// File: rtl/scl_timebase.sv
module scl_timebase #(
  parameter int REG_W    = 32,
  parameter int BASE_W   = 4,
  parameter int PH_W     = 4,
  parameter int BASE_LSB = 0,
  parameter int LO_LSB   = 12,
  parameter int HI_LSB   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [REG_W-1:0] timing_reg,
  input  logic             scl_in,
  output logic             scl_drive_low,
  output logic             fall_stb,
  output logic             rise_stb,
  output logic             sample_stb
);
  localparam int PRE_W = (1 << BASE_W) - 1;
  localparam int EL_W  = PRE_W + PH_W + 1;
  localparam logic [REG_W-1:0] FIELD_MASK =
    (((REG_W)'(1) << BASE_W) - 1'b1) << BASE_LSB |
    (((REG_W)'(1) << PH_W) - 1'b1) << LO_LSB |
    (((REG_W)'(1) << PH_W) - 1'b1) << HI_LSB;

  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH} st_t;
  st_t st;

  logic [BASE_W-1:0] base_q;
  logic [PH_W-1:0]   hi_q, lo_q, ph_cnt;
  logic [PRE_W-1:0]  pre_cnt, pre_mask;
  logic [PRE_W:0]    pow_b;
  logic [EL_W-1:0]   hi_len, elapsed;
  logic              run, tick, low_end, high_end;
  logic              unused_bits;

  assign unused_bits = ^(timing_reg & ~FIELD_MASK);

  assign pow_b    = (PRE_W+1)'(1) << base_q;
  assign pre_mask = PRE_W'(pow_b - 1'b1);

  assign run      = (st == ST_LOW) || (st == ST_HIGH && scl_in);
  assign tick     = run && (pre_cnt == pre_mask);
  assign low_end  = (st == ST_LOW)  && tick && (ph_cnt == lo_q);
  assign high_end = (st == ST_HIGH) && tick && (ph_cnt == hi_q);

  assign hi_len  = {{(EL_W-PH_W-1){1'b0}}, {1'b0, hi_q} + 1'b1} << base_q;
  assign elapsed = ({{(EL_W-PH_W){1'b0}}, ph_cnt} << base_q)
                 | {{(EL_W-PRE_W){1'b0}}, pre_cnt};

  assign scl_drive_low = (st == ST_LOW);
  assign rise_stb      = low_end;
  assign fall_stb      = enable && ((st == ST_IDLE) || high_end);
  assign sample_stb    = (st == ST_HIGH) && scl_in && (elapsed == (hi_len >> 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      pre_cnt <= '0;
      ph_cnt  <= '0;
      base_q  <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
    end else if (!enable) begin
      st      <= ST_IDLE;
      pre_cnt <= '0;
      ph_cnt  <= '0;
    end else if (fall_stb) begin
      st      <= ST_LOW;
      pre_cnt <= '0;
      ph_cnt  <= '0;
      base_q  <= timing_reg[BASE_LSB +: BASE_W];
      lo_q    <= timing_reg[LO_LSB +: PH_W];
      hi_q    <= timing_reg[HI_LSB +: PH_W];
    end else begin
      if (tick)     pre_cnt <= '0;
      else if (run) pre_cnt <= pre_cnt + 1'b1;
      if (low_end) begin
        st     <= ST_HIGH;
        ph_cnt <= '0;
      end else if (tick) begin
        ph_cnt <= ph_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/scl_timebase_chk.sv
module scl_timebase_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic scl_in,
  input logic scl_drive_low,
  input logic fall_stb,
  input logic rise_stb,
  input logic sample_stb
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!scl_drive_low && !rise_stb && !sample_stb)); // R1

  AST_LOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && scl_drive_low && !rise_stb) |=> scl_drive_low); // R2

  AST_STRETCH_NO_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    !scl_in |-> !sample_stb); // R6

  AST_SAMPLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> !scl_drive_low); // R7

  AST_FALL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && fall_stb) |=> scl_drive_low); // R8

  AST_RISE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && rise_stb) |=> !scl_drive_low); // R8

  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_stb, fall_stb})); // R8
endmodule

bind scl_timebase scl_timebase_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .scl_in(scl_in),
  .scl_drive_low(scl_drive_low), .fall_stb(fall_stb),
  .rise_stb(rise_stb), .sample_stb(sample_stb)
);

// File: tb/tb_scl_timebase.sv
`timescale 1ns/1ps
module tb_scl_timebase;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [31:0] treg = '0;
  logic        stretch = 1'b0;
  logic        scl_in;
  logic        scl_drive_low, fall_stb, rise_stb, sample_stb;
  int          total = 0;
  int          bad = 0;

  always #4 clk = ~clk;
  assign scl_in = !scl_drive_low && !stretch;

  scl_timebase dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .timing_reg(treg),
    .scl_in(scl_in), .scl_drive_low(scl_drive_low), .fall_stb(fall_stb),
    .rise_stb(rise_stb), .sample_stb(sample_stb)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int b, input int h, input int l, input logic [19:0] j);
    return {j[19:8], 4'(h), 4'(l), j[7:0], 4'(b)};
  endfunction

  task automatic observe(input int b, input int h, input int l, input int sl,
                         input bit chg, input logic [31:0] nv);
    int lo_n = 0, hi_n = 0, rise_at = -1, fall_at = -1, samp_at = -1, samp_n = 0, guard = 0;
    int exp_l = (l + 1) << b;
    int exp_h = (h + 1) << b;
    while (!scl_drive_low && guard < 8) begin @(negedge clk); #1; guard++; end
    while (scl_drive_low) begin
      if (rise_stb) begin rise_at = lo_n; if (sl > 0) stretch = 1'b1; end
      if (chg && lo_n == 0) treg = nv;
      lo_n++;
      @(negedge clk); #1;
    end
    while (!scl_drive_low) begin
      if (sl > 0 && hi_n == sl) begin stretch = 1'b0; #1; end
      if (sample_stb) begin samp_n++; samp_at = hi_n; end
      if (fall_stb) fall_at = hi_n;
      hi_n++;
      if (hi_n > exp_h + sl + 4) break;
      @(negedge clk); #1;
    end
    stretch = 1'b0;
    chk(lo_n == exp_l, "R2 low phase length", lo_n, exp_l);
    chk(rise_at == exp_l - 1, "R8 rise strobe position", rise_at, exp_l - 1);
    if (sl > 0) chk(hi_n == exp_h + sl, "R6 stretched high length", hi_n, exp_h + sl);
    else        chk(hi_n == exp_h, "R3 high phase length", hi_n, exp_h);
    chk(samp_n == 1, "R7 sample strobe count", samp_n, 1);
    chk(samp_at == sl + exp_h / 2, "R7 sample strobe position", samp_at, sl + exp_h / 2);
    chk(fall_at == hi_n - 1, "R8 fall strobe position", fall_at, hi_n - 1);
    if (sl == 0)
      chk(lo_n + hi_n == (1 << b) * (h + l + 2), "R4 period", lo_n + hi_n, (1 << b) * (h + l + 2));
  endtask

  task automatic restart(input logic [31:0] v);
    enable = 1'b0;
    @(negedge clk); #1;
    @(negedge clk); #1;
    treg = v;
    enable = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2417));
    @(negedge clk); #1;
    chk(!scl_drive_low && !rise_stb && !sample_stb && !fall_stb, "R1 reset quiet",
        {scl_drive_low, rise_stb, sample_stb, fall_stb}, 0);
    @(negedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!scl_drive_low && !rise_stb && !sample_stb, "R1 idle quiet",
        {scl_drive_low, rise_stb, sample_stb}, 0);

    restart(mk(0, 0, 0, 20'h0));
    observe(0, 0, 0, 0, 1'b0, '0);
    observe(0, 0, 0, 0, 1'b0, '0);

    restart(mk(2, 3, 1, 20'h0));
    observe(2, 3, 1, 0, 1'b0, '0);
    observe(2, 3, 1, 5, 1'b0, '0);
    observe(2, 3, 1, 1, 1'b0, '0);

    restart(mk(1, 2, 2, 20'h0));
    observe(1, 2, 2, 0, 1'b1, mk(0, 4, 1, 20'h0)); // R10 old fields kept this period
    observe(0, 4, 1, 0, 1'b0, '0);                 // R10 new fields next period

    while (scl_drive_low) begin @(negedge clk); #1; end
    @(negedge clk); #1;
    enable = 1'b0;
    @(negedge clk); #1;
    chk(!scl_drive_low && !rise_stb && !sample_stb && !fall_stb, "R9 disable aborts",
        {scl_drive_low, rise_stb, sample_stb, fall_stb}, 0);
    @(negedge clk); #1;
    treg = mk(3, 1, 2, 20'h0);
    enable = 1'b1;
    observe(3, 1, 2, 0, 1'b0, '0);                 // R9 full first phase

    restart(mk(2, 5, 6, 20'hFFFFF));               // R5 junk in unused bits
    observe(2, 5, 6, 0, 1'b0, '0);
    restart(mk(2, 5, 6, 20'h5A3C6));               // R5
    observe(2, 5, 6, 2, 1'b0, '0);

    for (int i = 0; i < 8; i++) begin
      int b = $urandom % 5;
      int h = $urandom % 16;
      int l = $urandom % 16;
      int sl = (i % 2 == 1) ? ($urandom % 6) : 0;
      restart(mk(b, h, l, 20'($urandom)));
      observe(b, h, l, 0, 1'b0, '0);
      observe(b, h, l, sl, 1'b0, '0);
    end

    restart(mk(15, 0, 0, 20'h0));
    observe(15, 0, 0, 0, 1'b0, '0);

    enable = 1'b0;
    @(negedge clk); #1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule